// File: doc/BRIEF.md
# Tone-Pair Guard-Time Steering Validator

This block replaces the analog RC steering network that sits behind a tone-pair frequency detector. The detector supplies a raw "frequencies valid" flag and the 4-bit code of the pair it currently sees. The validator debounces that flag in time. A tone is accepted only after the flag has held high for a loadable tone-present guard interval. Once accepted, it is released only after the flag has held low for a separate, loadable tone-absent interval. The two intervals give hysteresis: short bursts such as speech are rejected, and short dropouts inside a real tone are ridden through.

On acceptance the code is captured into a receive data register. After a fixed settling delay the steering output rises, and a one-cycle new-data pulse is issued for downstream status and interrupt logic. The captured code stays valid after the tone ends, until the next accepted tone overwrites it. The guard intervals are counts of clock ticks, so any clock rate can be used with a suitable count.

Top module: `tone_steer`

## Requirements
- R1: While the block is in the tone-absent state, a tone is accepted at the clock edge where `tone_det` has been sampled high on present_ticks+1 consecutive edges. `tone_code` sampled at that edge appears on `rx_code` after that edge.
- R2: `rx_code` changes only on an acceptance. After release it keeps the last accepted code.
- R3: If `tone_det` falls before the present guard count completes, no acceptance happens and `rx_code` is unchanged. A later tone must complete a fresh, full count.
- R4: `steer` rises SETTLE_CYC clock edges after the accepting edge. `new_data` is high for exactly the one cycle in which `steer` first reads high.
- R5: While the tone is accepted, the block releases (`steer` falls) at the edge where `tone_det` has been sampled low on absent_ticks+1 consecutive edges. Shorter dropouts change neither `steer` nor `rx_code`.
- R6: `idle` is the status view of the steering state. It reads 1 when a valid absence holds and 0 when a valid tone holds, so it is always the complement of `steer`.
- R7: A guard count of zero accepts on the first edge that samples `tone_det` high, and releases on the first edge that samples it low.
- R8: A synchronous `rst` puts the block in the tone-absent state: `steer`=0, `idle`=1, `new_data`=0 and `rx_code`=0.
- R9: While a tone is accepted or settling, changes on `tone_code` do not alter `rx_code`, and no further `new_data` pulse is produced while `tone_det` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tone_det | input | 1 | Early-detect flag from the frequency detector |
| tone_code | input | CODE_W | Code of the pair currently detected |
| present_ticks | input | CNT_W | Tone-present guard count, in ticks |
| absent_ticks | input | CNT_W | Tone-absent guard count, in ticks |
| rx_code | output | CODE_W | Receive data register |
| steer | output | 1 | Delayed steering, high while a tone is accepted |
| idle | output | 1 | Status view, high while a valid absence holds |
| new_data | output | 1 | One-cycle pulse on each acceptance |

## Verification
On every cycle, the embedded properties check four things. The receive register moves only on an accepting edge. The steering flag rises only out of the settling phase. It falls only after the detect flag was low. The new-data pulse lines up with the rising edge of the steering flag. Only the bench scenarios can show the exact cycle counts: acceptance after the present guard, release after the absent guard, the settling delay, and the zero-count corner. The same holds for rejection of short bursts, riding through short dropouts and the reset state, which the behavioural model checks cycle by cycle.

// File: rtl/tone_steer_pkg.sv
package tone_steer_pkg;
   typedef enum logic [1:0] {
      ST_ABSENT  = 2'd0,
      ST_SETTLE  = 2'd1,
      ST_PRESENT = 2'd2
   } steer_state_t;
endpackage

// File: rtl/steer_guard_timer.sv
module steer_guard_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             hit
);
   logic [CNT_W-1:0] cnt_q;

   initial begin
      if (CNT_W < 1) $error("steer_guard_timer: CNT_W must be at least 1");
   end

   assign hit = en && run && (cnt_q >= limit);

   always_ff @(posedge clk) begin
      if (rst || !en || !run || hit) cnt_q <= '0;
      else                           cnt_q <= cnt_q + 1'b1;
   end

   // R1 / R5: a running count only exists if the qualifying level was seen
   p_cnt_from_run_r1: assert property (@(posedge clk) disable iff (rst)
      (cnt_q != '0) |-> $past(en && run));
endmodule

// File: rtl/steer_settle.sv
module steer_settle #(
   parameter int SETTLE_CYC = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic due
);
   localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

   logic busy_q;

   initial begin
      if (SETTLE_CYC < 1) $error("steer_settle: SETTLE_CYC must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst)        busy_q <= 1'b0;
      else if (start) busy_q <= 1'b1;
      else if (due)   busy_q <= 1'b0;
   end

   generate
      if (SETTLE_CYC == 1) begin : g_single
         assign due = busy_q;
      end else begin : g_count
         logic [SW-1:0] scnt_q;
         always_ff @(posedge clk) begin
            if (rst || !busy_q || due) scnt_q <= '0;
            else                       scnt_q <= scnt_q + 1'b1;
         end
         assign due = busy_q && (scnt_q == SW'(SETTLE_CYC - 1));
      end
   endgenerate

   // R4: a new acceptance never arrives while a settle is still pending
   p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
      start |-> !busy_q);
endmodule

// File: rtl/steer_rx_reg.sv
module steer_rx_reg #(
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [CODE_W-1:0] d,
   output logic [CODE_W-1:0] q
);
   initial begin
      if (CODE_W < 1) $error("steer_rx_reg: CODE_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= d;
   end

   // R2: the register moves only on a load
   p_code_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !$stable(q) |-> $past(load));
endmodule

// File: rtl/tone_steer.sv
module tone_steer
   import tone_steer_pkg::*;
#(
   parameter int CODE_W     = 4,
   parameter int CNT_W      = 16,
   parameter int SETTLE_CYC = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tone_det,
   input  logic [CODE_W-1:0] tone_code,
   input  logic [CNT_W-1:0]  present_ticks,
   input  logic [CNT_W-1:0]  absent_ticks,
   output logic [CODE_W-1:0] rx_code,
   output logic              steer,
   output logic              idle,
   output logic              new_data
);
   steer_state_t state_q;
   logic         p_hit, a_hit, settle_due;
   logic         steer_q, nd_q;

   initial begin
      if (CODE_W < 1)     $error("tone_steer: CODE_W must be at least 1");
      if (CNT_W < 1)      $error("tone_steer: CNT_W must be at least 1");
      if (SETTLE_CYC < 1) $error("tone_steer: SETTLE_CYC must be at least 1");
   end

   steer_guard_timer #(.CNT_W(CNT_W)) u_present (
      .clk(clk), .rst(rst), .en(state_q == ST_ABSENT), .run(tone_det),
      .limit(present_ticks), .hit(p_hit));

   steer_guard_timer #(.CNT_W(CNT_W)) u_absent (
      .clk(clk), .rst(rst), .en(state_q == ST_PRESENT), .run(!tone_det),
      .limit(absent_ticks), .hit(a_hit));

   steer_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk(clk), .rst(rst), .start(p_hit), .due(settle_due));

   steer_rx_reg #(.CODE_W(CODE_W)) u_rx (
      .clk(clk), .rst(rst), .load(p_hit), .d(tone_code), .q(rx_code));

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_ABSENT;
         steer_q <= 1'b0;
         nd_q    <= 1'b0;
      end else begin
         nd_q <= 1'b0;
         case (state_q)
            ST_ABSENT:  if (p_hit) state_q <= ST_SETTLE;
            ST_SETTLE:  if (settle_due) begin
                           state_q <= ST_PRESENT;
                           steer_q <= 1'b1;
                           nd_q    <= 1'b1;
                        end
            ST_PRESENT: if (a_hit) begin
                           state_q <= ST_ABSENT;
                           steer_q <= 1'b0;
                        end
            default:    state_q <= ST_ABSENT;
         endcase
      end
   end

   assign steer    = steer_q;
   assign idle     = !steer_q;
   assign new_data = nd_q;

   // R4: pulse coincides with the first cycle of steering
   p_pulse_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
      nd_q |-> (steer_q && !$past(steer_q)));
   // R4: steering only rises out of the settling phase
   p_rise_after_settle_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(steer_q) |-> $past(state_q == ST_SETTLE));
   // R5: steering only falls after the detect flag was sampled low
   p_fall_needs_gap_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(steer_q) |-> $past(!tone_det));
endmodule

// File: tb/tb_tone_steer.sv
module tb_tone_steer;
   localparam int CODE_W = 4;
   localparam int CNT_W  = 16;
   localparam int SETTLE = 2;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              tone_det = 1'b0;
   logic [CODE_W-1:0] tone_code = '0;
   logic [CNT_W-1:0]  present_ticks = 16'd3;
   logic [CNT_W-1:0]  absent_ticks = 16'd2;
   logic [CODE_W-1:0] rx_code;
   logic              steer, idle, new_data;

   int tests = 0, fails = 0;
   bit done = 0;
   string cur_req = "R8";

   // behavioural reference model
   int m_state = 0, m_hi = 0, m_lo = 0, m_sc = 0;
   int m_code = 0, m_steer = 0, m_nd = 0;
   int m_pulses = 0, d_pulses = 0;

   always #5 clk = ~clk;

   tone_steer #(.CODE_W(CODE_W), .CNT_W(CNT_W), .SETTLE_CYC(SETTLE)) dut (
      .clk(clk), .rst(rst), .tone_det(tone_det), .tone_code(tone_code),
      .present_ticks(present_ticks), .absent_ticks(absent_ticks),
      .rx_code(rx_code), .steer(steer), .idle(idle), .new_data(new_data));

   always @(posedge clk) begin
      if (rst) begin
         m_state = 0; m_hi = 0; m_lo = 0; m_sc = 0;
         m_code = 0; m_steer = 0; m_nd = 0;
      end else begin
         m_nd = 0;
         if (m_state == 0) begin
            if (tone_det) begin
               if (m_hi == int'(present_ticks)) begin
                  m_code = int'(tone_code); m_state = 1; m_sc = 0; m_hi = 0;
               end else m_hi++;
            end else m_hi = 0;
         end else if (m_state == 1) begin
            if (m_sc == SETTLE - 1) begin
               m_state = 2; m_steer = 1; m_nd = 1; m_lo = 0; m_pulses++;
            end else m_sc++;
         end else begin
            if (!tone_det) begin
               if (m_lo == int'(absent_ticks)) begin
                  m_state = 0; m_steer = 0; m_hi = 0;
               end else m_lo++;
            end else m_lo = 0;
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         chk(cur_req, "rx_code", int'(rx_code), m_code);
         chk(cur_req, "steer", int'(steer), m_steer);
         chk("R6", "idle", int'(idle), 1 - m_steer);
         chk("R4", "new_data", int'(new_data), m_nd);
         if (new_data) d_pulses++;
      end
   end

   task automatic drive(input logic d, input int c, input int n);
      tone_det  = d;
      tone_code = CODE_W'(c);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk("R8", "reset rx_code", int'(rx_code), 0);
      chk("R8", "reset idle", int'(idle), 1);

      cur_req = "R1";
      drive(1, 5, 10);
      chk("R1", "accepted code", int'(rx_code), 5);
      chk("R4", "steer after settle", int'(steer), 1);

      cur_req = "R5";
      drive(0, 5, 2);
      drive(1, 5, 3);
      chk("R5", "dropout ridden", int'(steer), 1);

      cur_req = "R9";
      drive(1, 9, 4);
      chk("R9", "code held while active", int'(rx_code), 5);

      cur_req = "R2";
      drive(0, 9, 6);
      chk("R2", "released", int'(steer), 0);
      chk("R2", "code kept after release", int'(rx_code), 5);

      cur_req = "R3";
      drive(1, 7, 3);
      drive(0, 7, 3);
      drive(1, 7, 2);
      drive(0, 7, 4);
      chk("R3", "burst rejected", int'(rx_code), 5);
      chk("R3", "no steering", int'(steer), 0);

      cur_req = "R7";
      present_ticks = '0; absent_ticks = '0;
      drive(1, 12, 1);
      drive(0, 12, 6);
      chk("R7", "zero-count accept", int'(rx_code), 12);
      chk("R7", "zero-count release", int'(steer), 0);

      cur_req = "R8";
      present_ticks = 16'd1;
      drive(1, 3, 6);
      chk("R1", "second accept", int'(rx_code), 3);
      rst = 1'b1;
      drive(1, 3, 2);
      rst = 1'b0;
      chk("R8", "reset rx_code", int'(rx_code), 0);
      chk("R8", "reset steer", int'(steer), 0);
      chk("R8", "reset new_data", int'(new_data), 0);
      drive(0, 0, 2);

      chk("R4", "pulse count vs model", d_pulses, m_pulses);
      chk("R4", "pulse count", d_pulses, 3);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule